// File: doc/BRIEF.md
# Relaxation-Oscillator Capacitive Touch Scanner

The block turns a relaxation-oscillator signal into a capacitance measurement. It counts the oscillator's rising edges during a gate window whose length is a fixed number of reference-clock enables. A finger on an electrode adds capacitance, which slows the oscillator, so the count falls when the electrode is touched.

Several electrodes share one counter. A one-hot select output connects each electrode's oscillator in turn, and the next electrode is selected as soon as a window closes. The block keeps a baseline for each electrode. The baseline follows slow environmental drift and stays fixed while that electrode reads as touched. Each finished window produces a one-cycle result strobe. The strobe carries the electrode index, the raw count, the signed difference between baseline and count, and an updated per-electrode touch flag.

Top module: `rosc_touch_scanner`

## Requirements
- R1: While rst_ni is low, sel_o is 1 (electrode 0 selected), done_o is 0, count_o is 0, delta_o is 0 and touch_o is all zeros.
- R2: osc_i passes through a two-flop synchronizer. The block counts each low-to-high transition at the synchronizer output once, into the window that is open in the cycle the transition is detected.
- R3: A window closes in the clock cycle in which ref_tick_i is high for the GATE_TICKS-th time since the window opened. Cycles with ref_tick_i low do not advance the window.
- R4: The edge count saturates at 2^CNT_W-1 and does not wrap.
- R5: sel_o always has exactly one bit set. Bit k selects electrode k. The selection changes only when a window closes, and it advances 0,1,...,N_ELEM-1,0.
- R6: The clock edge after a window closes raises done_o for exactly one cycle. At that edge done_idx_o takes the measured electrode, count_o takes its count and delta_o takes its difference. All three hold until the next result.
- R7: The first result of each electrode after reset loads the count into its baseline and reports delta_o = 0 with that electrode's touch flag 0.
- R8: From the second result on, delta_o = baseline − count as a signed value of CNT_W+1 bits, so a touch gives a positive value. touch_o[k] is set when delta_o > THRESH and cleared otherwise. It holds its value between results of electrode k.
- R9: For a result that is not a touch, the baseline becomes baseline + ((count − baseline) >>> SHIFT), using an arithmetic (floor) shift. The default SHIFT is 4.
- R10: For a result that is a touch, the baseline of that electrode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference-clock enable that times the gate window |
| osc_i | input | 1 | Relaxation oscillator of the selected electrode, asynchronous |
| sel_o | output | N_ELEM | One-hot electrode select |
| done_o | output | 1 | One-cycle result strobe |
| done_idx_o | output | $clog2(N_ELEM) | Electrode index of the last result |
| count_o | output | CNT_W | Raw edge count of the last result |
| delta_o | output | CNT_W+1 | Signed baseline minus count of the last result |
| touch_o | output | N_ELEM | Per-electrode touch flags |

## Verification
Every electrode first runs the same oscillator period, which exercises baseline seeding and shows that a steady input gives no touch. One electrode is then slowed so that its count drops by more than the threshold. This shows the touch decision and the frozen baseline, and it shows that restoring the period clears the flag. Another electrode is then driven fast enough to saturate the counter. This separates wrapping from saturation and checks that the baseline steps toward a higher count by the shifted difference. Finally, a sparse reference enable separates window timing in ref ticks from timing in clock cycles.

// File: rtl/rosc_pkg.sv
package rosc_pkg;
  typedef enum logic [1:0] {
    ACT_SEED  = 2'd0,
    ACT_TRACK = 2'd1,
    ACT_HOLD  = 2'd2
  } trk_act_e;
endpackage

// File: rtl/rosc_edge_counter.sv
module rosc_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_i,
  input  logic             close_i,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sync1_q, sync2_q, prev_q, rise;
  logic [CNT_W-1:0] cnt_q;

  assign rise     = sync2_q & ~prev_q;
  assign result_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_W'(rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= osc_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      cnt_q   <= close_i ? '0 : result_o;
    end
  end
endmodule

// File: rtl/rosc_gate_timer.sv
module rosc_gate_timer #(
  parameter int GATE_TICKS = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic close_o
);
  localparam int TICK_W = $clog2(GATE_TICKS);
  localparam logic [TICK_W-1:0] LAST = TICK_W'(GATE_TICKS - 1);

  logic [TICK_W-1:0] tick_q;

  assign close_o = tick_i && (tick_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tick_q <= '0;
    else if (close_o) tick_q <= '0;
    else if (tick_i)  tick_q <= tick_q + 1'b1;
  end
endmodule

// File: rtl/rosc_scan_sel.sv
module rosc_scan_sel #(
  parameter int N_ELEM = 4,
  localparam int IDX_W = $clog2(N_ELEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              close_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [N_ELEM-1:0] sel_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_ELEM - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_o <= '0;
    else if (close_i) idx_o <= (idx_o == IDX_LAST) ? '0 : idx_o + 1'b1;
  end

  for (genvar g = 0; g < N_ELEM; g++) begin : g_sel
    assign sel_o[g] = (idx_o == IDX_W'(g));
  end
endmodule

// File: rtl/rosc_baseline_tracker.sv
module rosc_baseline_tracker
  import rosc_pkg::*;
#(
  parameter int N_ELEM = 4,
  parameter int CNT_W  = 16,
  parameter int THRESH = 150,
  parameter int SHIFT  = 4,
  localparam int IDX_W = $clog2(N_ELEM)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    close_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [CNT_W-1:0]        sample_i,
  output logic                    done_o,
  output logic [IDX_W-1:0]        done_idx_o,
  output logic [CNT_W-1:0]        count_o,
  output logic signed [CNT_W:0]   delta_o,
  output logic [N_ELEM-1:0]       touch_o
);
  localparam logic signed [CNT_W:0] THR = (CNT_W+1)'(THRESH);

  logic [CNT_W-1:0]        base_q [N_ELEM];
  logic [N_ELEM-1:0]       seeded_q;
  logic [CNT_W-1:0]        cur_base;
  logic signed [CNT_W:0]   diff, rise_diff, step, base_sum;
  logic [CNT_W-1:0]        base_next;
  trk_act_e                act;

  assign cur_base  = base_q[idx_i];
  assign diff      = $signed({1'b0, cur_base}) - $signed({1'b0, sample_i});
  assign rise_diff = $signed({1'b0, sample_i}) - $signed({1'b0, cur_base});
  assign step      = rise_diff >>> SHIFT;
  assign base_sum  = $signed({1'b0, cur_base}) + step;
  assign base_next = base_sum[CNT_W-1:0];

  always_comb begin
    if (!seeded_q[idx_i])  act = ACT_SEED;
    else if (diff > THR)   act = ACT_HOLD;
    else                   act = ACT_TRACK;
  end

  for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
    logic hit;
    assign hit = close_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]   <= '0;
        seeded_q[g] <= 1'b0;
        touch_o[g]  <= 1'b0;
      end else if (hit) begin
        seeded_q[g] <= 1'b1;
        touch_o[g]  <= (act == ACT_HOLD);
        case (act)
          ACT_SEED:  base_q[g] <= sample_i;
          ACT_TRACK: base_q[g] <= base_next;
          default:   base_q[g] <= base_q[g];
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      done_idx_o <= '0;
      count_o    <= '0;
      delta_o    <= '0;
    end else begin
      done_o <= close_i;
      if (close_i) begin
        done_idx_o <= idx_i;
        count_o    <= sample_i;
        delta_o    <= (act == ACT_SEED) ? '0 : diff;
      end
    end
  end
endmodule

// File: rtl/rosc_touch_scanner.sv
module rosc_touch_scanner #(
  parameter int N_ELEM     = 4,
  parameter int CNT_W      = 16,
  parameter int GATE_TICKS = 8192,
  parameter int THRESH     = 150,
  parameter int SHIFT      = 4,
  localparam int IDX_W     = $clog2(N_ELEM)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref_tick_i,
  input  logic                  osc_i,
  output logic [N_ELEM-1:0]     sel_o,
  output logic                  done_o,
  output logic [IDX_W-1:0]      done_idx_o,
  output logic [CNT_W-1:0]      count_o,
  output logic signed [CNT_W:0] delta_o,
  output logic [N_ELEM-1:0]     touch_o
);
  logic             close;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] sample;

  rosc_gate_timer #(.GATE_TICKS(GATE_TICKS)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(ref_tick_i), .close_o(close)
  );

  rosc_edge_counter #(.CNT_W(CNT_W)) u_edges (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_i(osc_i), .close_i(close),
    .result_o(sample)
  );

  rosc_scan_sel #(.N_ELEM(N_ELEM)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .close_i(close), .idx_o(idx), .sel_o(sel_o)
  );

  rosc_baseline_tracker #(
    .N_ELEM(N_ELEM), .CNT_W(CNT_W), .THRESH(THRESH), .SHIFT(SHIFT)
  ) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .close_i(close), .idx_i(idx),
    .sample_i(sample), .done_o(done_o), .done_idx_o(done_idx_o),
    .count_o(count_o), .delta_o(delta_o), .touch_o(touch_o)
  );
endmodule

// File: rtl/rosc_touch_scanner_chk.sv
module rosc_touch_scanner_chk #(
  parameter int N_ELEM = 4,
  parameter int CNT_W  = 16,
  parameter int THRESH = 150,
  localparam int IDX_W = $clog2(N_ELEM)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ref_tick_i,
  input logic [N_ELEM-1:0]     sel_o,
  input logic                  done_o,
  input logic [IDX_W-1:0]      done_idx_o,
  input logic signed [CNT_W:0] delta_o,
  input logic [N_ELEM-1:0]     touch_o
);
  a_r5_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == 1);

  a_r5_sel_moves_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> done_o);

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r3_done_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(ref_tick_i));

  a_r8_touch_matches_delta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (touch_o[done_idx_o] == (delta_o > $signed((CNT_W+1)'(THRESH)))));
endmodule

bind rosc_touch_scanner rosc_touch_scanner_chk #(
  .N_ELEM(N_ELEM), .CNT_W(CNT_W), .THRESH(THRESH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .sel_o(sel_o),
  .done_o(done_o), .done_idx_o(done_idx_o), .delta_o(delta_o), .touch_o(touch_o)
);

// File: tb/tb_rosc_touch_scanner.sv
module tb_rosc_touch_scanner;
  localparam int N     = 4;
  localparam int CW    = 6;
  localparam int GATE  = 150;
  localparam int TH    = 4;
  localparam int SH    = 4;
  localparam int MAXC  = (1 << CW) - 1;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            ref_tick_i = 1'b0;
  logic            osc_i = 1'b0;
  logic [N-1:0]    sel_o;
  logic            done_o;
  logic [1:0]      done_idx_o;
  logic [CW-1:0]   count_o;
  logic signed [CW:0] delta_o;
  logic [N-1:0]    touch_o;

  rosc_touch_scanner #(.N_ELEM(N), .CNT_W(CW), .GATE_TICKS(GATE), .THRESH(TH), .SHIFT(SH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .osc_i(osc_i),
    .sel_o(sel_o), .done_o(done_o), .done_idx_o(done_idx_o), .count_o(count_o),
    .delta_o(delta_o), .touch_o(touch_o)
  );

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0;
  int ref_div = 1;
  int hp [N] = '{3, 3, 3, 3};
  int ph = 0;

  // behavioural reference state
  bit m_s1, m_s2, m_prev;
  int m_cnt, m_tick, m_elem;
  int m_base [N];
  bit m_seed [N];
  bit m_touch [N];
  bit m_done;
  int m_idx, m_count, m_delta;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 60000) begin
      total++; bad++;
      $display("FAIL watchdog R6 act=%0d exp=%0d", cyc, 60000);
      finish_run();
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_cnt = 0; m_tick = 0; m_elem = 0;
      m_done = 0; m_idx = 0; m_count = 0; m_delta = 0;
      for (int k = 0; k < N; k++) begin m_base[k] = 0; m_seed[k] = 0; m_touch[k] = 0; end
    end else begin
      int nxt, d;
      bit cl;
      nxt = m_cnt + ((m_s2 && !m_prev) ? 1 : 0);
      if (nxt > MAXC) nxt = MAXC;
      cl = ref_tick_i && (m_tick == GATE - 1);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = osc_i;
      if (cl) m_tick = 0; else if (ref_tick_i) m_tick++;
      m_cnt = cl ? 0 : nxt;
      m_done = cl;
      if (cl) begin
        m_idx = m_elem; m_count = nxt;
        if (!m_seed[m_elem]) begin
          m_seed[m_elem] = 1; m_base[m_elem] = nxt; m_delta = 0; m_touch[m_elem] = 0;
        end else begin
          d = m_base[m_elem] - nxt;
          m_delta = d;
          m_touch[m_elem] = (d > TH);
          if (d <= TH) m_base[m_elem] = m_base[m_elem] + ((nxt - m_base[m_elem]) >>> SH);
        end
        m_elem = (m_elem + 1) % N;
      end
    end
  end

  // per-cycle comparison against the reference, then input drive
  always @(negedge clk_i) begin
    if (rst_ni) begin
      int cur;
      cur = 0;
      check(sel_o == N'(1 << m_elem), "R5 sel", int'(sel_o), 1 << m_elem);
      check(done_o == m_done, "R6 done", int'(done_o), int'(m_done));
      check(int'(done_idx_o) == m_idx, "R6 idx", int'(done_idx_o), m_idx);
      check(int'(count_o) == m_count, "R2 count", int'(count_o), m_count);
      check(int'(delta_o) == m_delta, "R8 delta", int'(delta_o), m_delta);
      for (int k = 0; k < N; k++) begin
        check(touch_o[k] == m_touch[k], "R8 touch", int'(touch_o[k]), int'(m_touch[k]));
        if (sel_o[k]) cur = k;
      end
      ph++;
      if (ph >= hp[cur]) begin osc_i <= ~osc_i; ph = 0; end
    end
    ref_tick_i <= ((cyc % ref_div) == 0);
  end

  int r_idx, r_cnt, r_dl, r_cyc;
  bit r_tch;

  task automatic wait_done();
    do @(negedge clk_i); while (!done_o);
    r_idx = int'(done_idx_o); r_cnt = int'(count_o); r_dl = int'(delta_o);
    r_tch = touch_o[done_idx_o]; r_cyc = cyc;
    @(negedge clk_i);
    check(done_o == 1'b0, "R6 pulse width", int'(done_o), 0);
  endtask

  task automatic wait_idx(int target);
    do wait_done(); while (r_idx != target);
  endtask

  initial begin
    int b2, b0, exp_b, c1;
    repeat (3) @(negedge clk_i);
    check(sel_o == 4'b0001, "R1 sel", int'(sel_o), 1);
    check(done_o == 1'b0, "R1 done", int'(done_o), 0);
    check(count_o == '0 && delta_o == '0, "R1 count/delta", int'(count_o), 0);
    check(touch_o == '0, "R1 touch", int'(touch_o), 0);
    rst_ni = 1'b1;

    // R7: first pass seeds every baseline, order follows R5
    for (int i = 0; i < N; i++) begin
      wait_done();
      check(r_idx == i, "R5 order", r_idx, i);
      check(r_dl == 0 && !r_tch, "R7 seed", r_dl, 0);
    end
    for (int i = 0; i < N; i++) begin
      wait_done();
      check(!r_tch, "R8 steady no touch", int'(r_tch), 0);
    end

    // slow electrode 2: count drops, touch, baseline frozen
    hp[2] = 5;
    wait_idx(2);
    check(r_tch, "R8 touch set", int'(r_tch), 1);
    check(r_dl > TH, "R8 delta above threshold", r_dl, TH + 1);
    b2 = r_cnt + r_dl;
    wait_idx(2);
    check(r_tch, "R8 touch held", int'(r_tch), 1);
    check(r_cnt + r_dl == b2, "R10 baseline frozen", r_cnt + r_dl, b2);
    hp[2] = 3;
    wait_idx(2);
    check(!r_tch, "R8 touch released", int'(r_tch), 0);

    // fast electrode 0: saturation and baseline drift
    hp[0] = 1;
    wait_idx(0);
    check(r_cnt == MAXC, "R4 saturate", r_cnt, MAXC);
    check(!r_tch, "R8 rise is no touch", int'(r_tch), 0);
    b0 = r_cnt + r_dl;
    exp_b = b0 + ((r_cnt - b0) >>> SH);
    wait_idx(0);
    check(r_cnt + r_dl == exp_b, "R9 baseline step", r_cnt + r_dl, exp_b);

    // sparse reference enable: window length in ref ticks
    ref_div = 3;
    wait_done();
    wait_done();
    c1 = r_cyc;
    wait_done();
    check(r_cyc - c1 == 3 * GATE, "R3 gate length", r_cyc - c1, 3 * GATE);

    finish_run();
  end
endmodule